// File: doc/BRIEF.md
# Video Acquisition Window Controller

This block sits in front of a video scaler. It receives video one pixel per clock, together with a horizontal strobe, a vertical strobe and a field identifier. From these it keeps a pixel position and a line position. It compares them with a programmed rectangle and produces a per-pixel qualifier that marks the pixels the scaler must take in. It also produces horizontal and vertical reference outputs for the region being scaled. Each of these can be a gate or a one-cycle start marker.

The rectangle is given as a start column, a start line, a width and a height. The vertical opening is kept two lines longer than the programmed height so the vertical filter can settle before its first output line. Every setting is captured at the selected vertical trigger edge, and the captured set governs the whole following field. The scale increments are also computed at that edge, as fixed-point ratios of input size to output size, and they use the nominal height rather than the extended one.

A tall window can reach past the end of a field. In that case the block blanks every field whose identifier is 1, which halves the output field rate. The block also raises a one-cycle request for inserting sliced data after the last scaled pixel of selected lines. It raises an almost-full flag from the fill level of the downstream FIFO.

Top module: `acq_window_ctrl`

## Requirements
- R1: Each trigger edge is selectable: `h_rise_i`=1 picks the rising edge of `href_i` and 0 picks the falling edge; `v_rise_i` does the same for `vref_i`. The pixel position becomes 0 in the cycle of a selected horizontal edge and then advances by one each clock. The line position becomes 0 at a selected vertical edge and otherwise advances by one at each selected horizontal edge.
- R2: While enabled, a pixel is active when its pixel position lies in [x_start, x_start+width) and its line position lies in [y_start, y_start+height+2). An active window therefore spans height+2 lines.
- R3: A captured trigger-condition value of 0 on `trig_cond_i` disables the window. While disabled, no pixel is active and the gate, marker and insertion-request outputs stay low.
- R4: At a vertical trigger, y_start+height is compared with a threshold: 262 when `std50_i`=0, or 312 when `std50_i`=1. If the sum reaches the threshold and `fid_i`=1, the field is dropped. For that whole field `field_drop_o` is 1 and no pixel, gate, marker or request is output.
- R5: All window, mode, polarity and insertion settings are captured only at a selected vertical edge. A change in the middle of a field has no effect until the next vertical edge.
- R6: `h_inc_o` = floor(width*1024/out_width), captured at the vertical edge. It is 1024 when out_width is 0, and it is raised to at least 293 (a zoom of 3.5) when it falls below that.
- R7: `v_inc_o` = floor(height*1024/out_height), computed from the nominal height without the two run-in lines. It is 1024 when out_height is 0 and is not clamped.
- R8: With `gate_mode_i`=1, `hgate_o` equals the active-pixel condition and `vgate_o` is high for every pixel of the window's lines. With `gate_mode_i`=0, `hgate_o` is a one-cycle marker at pixel x_start of each window line, and `vgate_o` is a one-cycle marker at pixel x_start of line y_start only.
- R9: When insertion is enabled, `vbi_req_o` is high for one cycle at pixel position x_start+width. This happens on each window line whose line position lies in [`vbi_first_i`, `vbi_last_i`].
- R10: `fifo_afull_o` is 1 exactly when `fifo_level_i` is 24 or more.
- R11: The pixel and line positions stop at 2047 instead of wrapping when strobes are missing.
- R12: With `valid_pol_i`=1, `dvalid_o` is high for active pixels. With `valid_pol_i`=0, it is low for active pixels and high otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| href_i | input | 1 | Horizontal reference strobe |
| vref_i | input | 1 | Vertical reference strobe |
| fid_i | input | 1 | Field identifier, sampled at the vertical trigger |
| h_rise_i | input | 1 | Horizontal trigger edge: 1 rising, 0 falling |
| v_rise_i | input | 1 | Vertical trigger edge: 1 rising, 0 falling |
| trig_cond_i | input | 2 | Acquisition enable code, 0 disables |
| std50_i | input | 1 | 1 selects the 312-line drop threshold, 0 the 262-line one |
| xo_i | input | 11 | Window start column |
| yo_i | input | 11 | Window start line |
| xs_i | input | 11 | Window width in pixels |
| ys_i | input | 11 | Nominal window height in lines |
| out_w_i | input | 11 | Scaled output width |
| out_h_i | input | 11 | Scaled output height |
| gate_mode_i | input | 1 | 1 gate outputs, 0 start markers |
| valid_pol_i | input | 1 | Qualifier polarity, 1 active-high |
| vbi_en_i | input | 1 | Enables insertion requests |
| vbi_first_i | input | 11 | First line of the insertion range |
| vbi_last_i | input | 11 | Last line of the insertion range |
| fifo_level_i | input | 6 | Downstream FIFO fill level |
| dvalid_o | output | 1 | Per-pixel acquisition qualifier |
| hgate_o | output | 1 | Horizontal gate or marker |
| vgate_o | output | 1 | Vertical gate or marker |
| vbi_req_o | output | 1 | Insertion request after the last scaled pixel |
| fifo_afull_o | output | 1 | FIFO almost-full flag |
| field_drop_o | output | 1 | Current field is dropped |
| h_inc_o | output | 21 | Horizontal increment, 10 fractional bits |
| v_inc_o | output | 21 | Vertical increment, 10 fractional bits |

## Verification
A wrong pixel or line count moves the first active pixel and changes the number of active pixels in a field. Because the counts restart at every selected edge, the error appears within the line or field in which it arises. A wrong captured setting or drop decision cannot show up before the next vertical edge. It then affects a whole field at once: it changes the field's active total, its gate and request counts, or `field_drop_o`. A faulty increment appears on the increment outputs right after the vertical edge that captures it.

// File: rtl/acqw_pkg.sv
`timescale 1ns/1ps
package acqw_pkg;

    typedef enum logic {
        REF_PULSE = 1'b0,
        REF_GATE  = 1'b1
    } ref_mode_e;

    // edge of interest on a strobe, given its present and previous level
    function automatic logic edge_hit(input logic now_v, input logic prev_v, input logic rise);
        return rise ? (now_v & ~prev_v) : (~now_v & prev_v);
    endfunction

endpackage

// File: rtl/acqw_edge_sel.sv
`timescale 1ns/1ps
module acqw_edge_sel (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_i,
    input  logic rise_i,
    output logic trig_o
);
    import acqw_pkg::*;

    typedef struct packed {
        logic prev;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = strobe_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign trig_o = edge_hit(strobe_i, st_q.prev, rise_i);

endmodule

// File: rtl/acqw_sat_cnt.sv
`timescale 1ns/1ps
module acqw_sat_cnt #(
    parameter int W = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         inc_i,
    output logic [W-1:0] cnt_o
);
    localparam logic [W-1:0] TOP = '1;

    typedef struct packed {
        logic [W-1:0] cnt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i)
            st_d.cnt = '0;
        else if (inc_i && (st_q.cnt != TOP))
            st_d.cnt = st_q.cnt + 1'b1;
    end

    // start parked at the top so nothing is inside a window before the first strobes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{cnt: TOP};
        else        st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;

endmodule

// File: rtl/acqw_ratio.sv
`timescale 1ns/1ps
module acqw_ratio #(
    parameter int NW   = 11,
    parameter int FRAC = 10,
    parameter int MIN  = 293
) (
    input  logic [NW-1:0]      num_i,
    input  logic [NW-1:0]      den_i,
    input  logic               clamp_i,
    output logic [NW+FRAC-1:0] inc_o
);
    localparam int OW = NW + FRAC;
    localparam logic [OW-1:0] ONE_V = OW'(1) << FRAC;
    localparam logic [OW-1:0] MIN_V = OW'(MIN);

    logic [OW-1:0] num_w;
    logic [OW-1:0] den_w;
    logic [OW-1:0] quo;

    always_comb begin
        num_w = {num_i, {FRAC{1'b0}}};
        den_w = {{FRAC{1'b0}}, den_i};
        quo   = (den_i == '0) ? ONE_V : (num_w / den_w);
        if (clamp_i && (quo < MIN_V))
            inc_o = MIN_V;
        else
            inc_o = quo;
    end

endmodule

// File: rtl/acq_window_ctrl.sv
`timescale 1ns/1ps
module acq_window_ctrl #(
    parameter int CW        = 11,
    parameter int FRAC      = 10,
    parameter int LVL_W     = 6,
    parameter int AFULL_LVL = 24,
    parameter int LINES60   = 262,
    parameter int LINES50   = 312,
    parameter int RUNIN     = 2,
    parameter int ZOOM_NUM  = 2,
    parameter int ZOOM_DEN  = 7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 href_i,
    input  logic                 vref_i,
    input  logic                 fid_i,
    input  logic                 h_rise_i,
    input  logic                 v_rise_i,
    input  logic [1:0]           trig_cond_i,
    input  logic                 std50_i,
    input  logic [CW-1:0]        xo_i,
    input  logic [CW-1:0]        yo_i,
    input  logic [CW-1:0]        xs_i,
    input  logic [CW-1:0]        ys_i,
    input  logic [CW-1:0]        out_w_i,
    input  logic [CW-1:0]        out_h_i,
    input  logic                 gate_mode_i,
    input  logic                 valid_pol_i,
    input  logic                 vbi_en_i,
    input  logic [CW-1:0]        vbi_first_i,
    input  logic [CW-1:0]        vbi_last_i,
    input  logic [LVL_W-1:0]     fifo_level_i,
    output logic                 dvalid_o,
    output logic                 hgate_o,
    output logic                 vgate_o,
    output logic                 vbi_req_o,
    output logic                 fifo_afull_o,
    output logic                 field_drop_o,
    output logic [CW+FRAC-1:0]   h_inc_o,
    output logic [CW+FRAC-1:0]   v_inc_o
);
    import acqw_pkg::*;

    localparam int INC_W   = CW + FRAC;
    localparam int INC_MIN = ((1 << FRAC) * ZOOM_NUM + ZOOM_DEN - 1) / ZOOM_DEN;
    localparam int SW      = CW + 1;
    localparam logic [SW-1:0]    LIM60  = SW'(LINES60);
    localparam logic [SW-1:0]    LIM50  = SW'(LINES50);
    localparam logic [SW-1:0]    EXTRA  = SW'(RUNIN);
    localparam logic [INC_W-1:0] INC_ONE = INC_W'(1) << FRAC;
    localparam int NSTRB = 2;   // index 0: horizontal, 1: vertical

    typedef struct packed {
        logic [1:0]       trig;
        logic [CW-1:0]    xo;
        logic [CW-1:0]    yo;
        logic [CW-1:0]    xs;
        logic [CW-1:0]    ys;
        ref_mode_e        gate;
        logic             pol;
        logic             vbi_en;
        logic [CW-1:0]    vbi_first;
        logic [CW-1:0]    vbi_last;
        logic             drop;
        logic [INC_W-1:0] hinc;
        logic [INC_W-1:0] vinc;
    } cfg_t;

    localparam cfg_t CFG_RST = '{
        trig:      2'b00,
        xo:        '0,
        yo:        '0,
        xs:        '0,
        ys:        '0,
        gate:      REF_GATE,
        pol:       1'b1,
        vbi_en:    1'b0,
        vbi_first: '0,
        vbi_last:  '0,
        drop:      1'b0,
        hinc:      INC_ONE,
        vinc:      INC_ONE
    };

    // ---------------- strobe edge selection ----------------
    logic [NSTRB-1:0] strb;
    logic [NSTRB-1:0] rise_sel;
    logic [NSTRB-1:0] trig;

    assign strb     = {vref_i, href_i};
    assign rise_sel = {v_rise_i, h_rise_i};

    for (genvar g = 0; g < NSTRB; g++) begin : g_edge
        acqw_edge_sel u_edge (
            .clk      (clk),
            .rst_n    (rst_n),
            .strobe_i (strb[g]),
            .rise_i   (rise_sel[g]),
            .trig_o   (trig[g])
        );
    end

    logic h_trig;
    logic v_trig;
    assign h_trig = trig[0];
    assign v_trig = trig[1];

    // ---------------- position counters ----------------
    logic [CW-1:0] pix_q;
    logic [CW-1:0] line_q;

    acqw_sat_cnt #(.W(CW)) u_pix (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (h_trig),
        .inc_i (1'b1),
        .cnt_o (pix_q)
    );

    acqw_sat_cnt #(.W(CW)) u_line (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (v_trig),
        .inc_i (h_trig),
        .cnt_o (line_q)
    );

    // ---------------- increments from live settings ----------------
    logic [INC_W-1:0] h_ratio;
    logic [INC_W-1:0] v_ratio;

    acqw_ratio #(.NW(CW), .FRAC(FRAC), .MIN(INC_MIN)) u_hratio (
        .num_i   (xs_i),
        .den_i   (out_w_i),
        .clamp_i (1'b1),
        .inc_o   (h_ratio)
    );

    acqw_ratio #(.NW(CW), .FRAC(FRAC), .MIN(INC_MIN)) u_vratio (
        .num_i   (ys_i),
        .den_i   (out_h_i),
        .clamp_i (1'b0),
        .inc_o   (v_ratio)
    );

    // ---------------- field settings, captured at the vertical trigger ----------------
    cfg_t cfg_d, cfg_q;
    logic [SW-1:0] depth_live;
    logic [SW-1:0] depth_lim;

    always_comb begin
        depth_live = {1'b0, yo_i} + {1'b0, ys_i};
        depth_lim  = std50_i ? LIM50 : LIM60;
        cfg_d      = cfg_q;
        if (v_trig) begin
            cfg_d.trig      = trig_cond_i;
            cfg_d.xo        = xo_i;
            cfg_d.yo        = yo_i;
            cfg_d.xs        = xs_i;
            cfg_d.ys        = ys_i;
            cfg_d.gate      = ref_mode_e'(gate_mode_i);
            cfg_d.pol       = valid_pol_i;
            cfg_d.vbi_en    = vbi_en_i;
            cfg_d.vbi_first = vbi_first_i;
            cfg_d.vbi_last  = vbi_last_i;
            cfg_d.drop      = fid_i && (depth_live >= depth_lim);
            cfg_d.hinc      = h_ratio;
            cfg_d.vinc      = v_ratio;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= CFG_RST;
        else        cfg_q <= cfg_d;
    end

    // ---------------- window decode ----------------
    logic          cur_gate;
    logic          cur_pol;
    logic [SW-1:0] x_end;
    logic [SW-1:0] y_end;
    logic          on;
    logic          h_in;
    logic          v_in;
    logic          act;
    logic          h_mark;
    logic          v_mark;
    logic          in_vbi_rng;

    assign cur_gate = (cfg_q.gate == REF_GATE);
    assign cur_pol  = cfg_q.pol;

    always_comb begin
        x_end      = {1'b0, cfg_q.xo} + {1'b0, cfg_q.xs};
        y_end      = {1'b0, cfg_q.yo} + {1'b0, cfg_q.ys} + EXTRA;
        on         = (cfg_q.trig != 2'b00) && !cfg_q.drop;
        h_in       = (pix_q >= cfg_q.xo) && ({1'b0, pix_q} < x_end);
        v_in       = (line_q >= cfg_q.yo) && ({1'b0, line_q} < y_end);
        act        = on && h_in && v_in;
        h_mark     = on && v_in && (pix_q == cfg_q.xo) && (cfg_q.xs != '0);
        v_mark     = h_mark && (line_q == cfg_q.yo);
        in_vbi_rng = (line_q >= cfg_q.vbi_first) && (line_q <= cfg_q.vbi_last);
    end

    assign dvalid_o     = cur_pol ? act : ~act;
    assign hgate_o      = cur_gate ? act : h_mark;
    assign vgate_o      = cur_gate ? (on && v_in) : v_mark;
    assign vbi_req_o    = on && cfg_q.vbi_en && v_in && in_vbi_rng &&
                          (cfg_q.xs != '0) && ({1'b0, pix_q} == x_end);
    assign fifo_afull_o = (fifo_level_i >= LVL_W'(AFULL_LVL));
    assign field_drop_o = cfg_q.drop;
    assign h_inc_o      = cfg_q.hinc;
    assign v_inc_o      = cfg_q.vinc;

endmodule

// File: rtl/acqw_chk.sv
`timescale 1ns/1ps
module acqw_chk #(
    parameter int CW      = 11,
    parameter int INC_W   = 21,
    parameter int INC_MIN = 293
) (
    input logic             clk,
    input logic             rst_n,
    input logic             htrig,
    input logic             vtrig,
    input logic [CW-1:0]    pix,
    input logic             cur_gate,
    input logic             cur_pol,
    input logic             dvalid_o,
    input logic             hgate_o,
    input logic             vbi_req_o,
    input logic             field_drop_o,
    input logic [INC_W-1:0] h_inc_o
);
    localparam logic [CW-1:0] TOP = '1;

    // R1
    htrig_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        htrig |=> (pix == '0));

    // R11
    pix_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pix == TOP && !htrig) |=> (pix == TOP));

    // R4
    drop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !vtrig |=> $stable(field_drop_o));

    // R4
    drop_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        field_drop_o |-> (dvalid_o == !cur_pol) && !hgate_o && !vbi_req_o);

    // R8
    hmark_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cur_gate && hgate_o && !htrig && !vtrig) |=> !hgate_o);

    // R9
    vbi_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vbi_req_o && !htrig && !vtrig) |=> !vbi_req_o);

    // R6
    hinc_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        h_inc_o >= INC_W'(INC_MIN));

endmodule

bind acq_window_ctrl acqw_chk #(
    .CW      (CW),
    .INC_W   (INC_W),
    .INC_MIN (INC_MIN)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .htrig        (h_trig),
    .vtrig        (v_trig),
    .pix          (pix_q),
    .cur_gate     (cur_gate),
    .cur_pol      (cur_pol),
    .dvalid_o     (dvalid_o),
    .hgate_o      (hgate_o),
    .vbi_req_o    (vbi_req_o),
    .field_drop_o (field_drop_o),
    .h_inc_o      (h_inc_o)
);

// File: tb/test_acq_window_ctrl.sv
`timescale 1ns/1ps
module test_acq_window_ctrl;

    localparam int LEN = 24;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic href_i = 0, vref_i = 0, fid_i = 0, h_rise_i = 1, v_rise_i = 1;
    logic [1:0] trig_cond_i = 0;
    logic std50_i = 0;
    logic [10:0] xo_i = 0, yo_i = 0, xs_i = 0, ys_i = 0, out_w_i = 0, out_h_i = 0;
    logic gate_mode_i = 1, valid_pol_i = 1, vbi_en_i = 0;
    logic [10:0] vbi_first_i = 0, vbi_last_i = 0;
    logic [5:0] fifo_level_i = 0;
    logic dvalid_o, hgate_o, vgate_o, vbi_req_o, fifo_afull_o, field_drop_o;
    logic [20:0] h_inc_o, v_inc_o;

    always #5 clk = ~clk;

    acq_window_ctrl i_acq_window_ctrl (
        .clk(clk), .rst_n(rst_n), .href_i(href_i), .vref_i(vref_i), .fid_i(fid_i),
        .h_rise_i(h_rise_i), .v_rise_i(v_rise_i), .trig_cond_i(trig_cond_i),
        .std50_i(std50_i), .xo_i(xo_i), .yo_i(yo_i), .xs_i(xs_i), .ys_i(ys_i),
        .out_w_i(out_w_i), .out_h_i(out_h_i), .gate_mode_i(gate_mode_i),
        .valid_pol_i(valid_pol_i), .vbi_en_i(vbi_en_i), .vbi_first_i(vbi_first_i),
        .vbi_last_i(vbi_last_i), .fifo_level_i(fifo_level_i), .dvalid_o(dvalid_o),
        .hgate_o(hgate_o), .vgate_o(vgate_o), .vbi_req_o(vbi_req_o),
        .fifo_afull_o(fifo_afull_o), .field_drop_o(field_drop_o),
        .h_inc_o(h_inc_o), .v_inc_o(v_inc_o)
    );

    typedef struct packed {
        int hr; int vr; int xo; int yo; int xs; int ys; int fid; int s50;
        int trig; int gate; int pol; int vben; int vf; int vl; int nl;
        int e_val; int e_first; int e_hg; int e_vg; int e_vbi; int e_drop;
    } vec_t;

    // hr vr xo yo xs ys fid s50 trig gate pol vben vf vl nl | val first hg vg vbi drop  (vg -1: not checked)
    localparam vec_t VEC [10] = '{
        '{1,1,2,1,8,3,0,0,1,1,1,1,2,3,10,      40,26,40,120,2,0},     // R2 R8 R9 rising edges, gates
        '{1,0,0,2,5,2,0,0,2,0,1,0,0,0,10,      20,72,4,1,0,0},        // R1 falling vertical, markers
        '{0,1,3,1,10,1,0,0,3,1,1,1,0,100,8,    30,7,30,72,3,0},       // R1 falling horizontal
        '{1,1,1,1,4,261,1,0,1,1,1,1,0,2000,20, 0,-1,0,0,0,1},         // R4 262 reached, fid 1
        '{1,1,1,1,4,261,0,0,1,1,1,1,0,2000,265,1052,25,1052,-1,263,0},// R4 fid 0 kept, R2 run-in
        '{1,1,1,1,4,260,1,0,1,1,1,0,0,0,265,   1048,25,1048,-1,0,0},  // R4 just below 262
        '{1,1,1,1,4,261,1,1,1,1,1,0,0,0,265,   1052,25,1052,-1,0,0},  // R4 50 Hz threshold not reached
        '{1,1,2,1,8,3,0,0,0,1,1,1,2,3,10,      0,-1,0,0,0,0},         // R3 disabled
        '{1,1,2,1,8,3,0,0,1,1,0,1,2,3,10,      40,26,40,120,2,0},     // R12 active-low qualifier
        '{1,1,1,1,4,311,1,1,1,1,1,1,0,2000,20, 0,-1,0,0,0,1}          // R4 312 reached in 50 Hz
    };

    int n_chk = 0;
    int n_fail = 0;
    int n_val, first, n_hg, n_vg, n_vbi;

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic apply(input vec_t v);
        h_rise_i = v.hr[0]; v_rise_i = v.vr[0];
        xo_i = 11'(v.xo); yo_i = 11'(v.yo); xs_i = 11'(v.xs); ys_i = 11'(v.ys);
        out_w_i = 11'(v.xs); out_h_i = 11'(v.ys);
        fid_i = v.fid[0]; std50_i = v.s50[0]; trig_cond_i = 2'(v.trig);
        gate_mode_i = v.gate[0]; valid_pol_i = v.pol[0]; vbi_en_i = v.vben[0];
        vbi_first_i = 11'(v.vf); vbi_last_i = 11'(v.vl);
    endtask

    task automatic run_field(input vec_t v, input int mid);
        n_val = 0; first = -1; n_hg = 0; n_vg = 0; n_vbi = 0;
        for (int f = 0; f < v.nl; f++) begin
            for (int s = 0; s < LEN; s++) begin
                if (f == 0 && s == 0) apply(v);
                if (f == mid && s == 0) begin xo_i = 11'd10; xs_i = 11'd1; end
                href_i = (s < 4);
                vref_i = (f == 0);
                step();
                if (dvalid_o == v.pol[0]) begin
                    n_val++;
                    if (first < 0) first = f * LEN + s;
                end
                if (hgate_o) n_hg++;
                if (vgate_o) n_vg++;
                if (vbi_req_o) n_vbi++;
            end
        end
    endtask

    task automatic latch_ratio(input int xs, input int ow, input int ys, input int oh);
        trig_cond_i = 0; h_rise_i = 1; v_rise_i = 1;
        xs_i = 11'(xs); out_w_i = 11'(ow); ys_i = 11'(ys); out_h_i = 11'(oh);
        href_i = 1; vref_i = 1; step();
        href_i = 0; vref_i = 0; step();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #2;
        // reset state (R3 disabled, R6 R7 unity increments)
        check("R3 reset dvalid", int'(dvalid_o), 0);
        check("R3 reset hgate", int'(hgate_o), 0);
        check("R3 reset vgate", int'(vgate_o), 0);
        check("R9 reset vbi_req", int'(vbi_req_o), 0);
        check("R4 reset field_drop", int'(field_drop_o), 0);
        check("R6 reset h_inc", int'(h_inc_o), 1024);
        check("R7 reset v_inc", int'(v_inc_o), 1024);

        for (int i = 0; i < 10; i++) begin
            run_field(VEC[i], -1);
            check($sformatf("R2 vec%0d active count", i), n_val, VEC[i].e_val);
            check($sformatf("R1 vec%0d first active step", i), first, VEC[i].e_first);
            check($sformatf("R8 vec%0d hgate count", i), n_hg, VEC[i].e_hg);
            if (VEC[i].e_vg >= 0)
                check($sformatf("R8 vec%0d vgate count", i), n_vg, VEC[i].e_vg);
            check($sformatf("R9 vec%0d vbi_req count", i), n_vbi, VEC[i].e_vbi);
            check($sformatf("R4 vec%0d field_drop", i), int'(field_drop_o), VEC[i].e_drop);
        end

        // R5: mid-field change is held off until the next vertical edge
        run_field(VEC[0], 2);
        check("R5 mid-field change active count", n_val, 40);
        check("R5 mid-field change first step", first, 26);
        begin
            vec_t w;
            w = VEC[0];
            w.xo = 10; w.xs = 1;
            run_field(w, -1);
            check("R5 next field active count", n_val, 5);
            check("R5 next field first step", first, 34);
        end

        // R6 R7 increments
        latch_ratio(720, 768, 288, 240);
        check("R6 h_inc 720/768", int'(h_inc_o), 960);
        check("R7 v_inc 288/240", int'(v_inc_o), 1228);
        latch_ratio(720, 200, 240, 0);
        check("R6 h_inc 720/200", int'(h_inc_o), 3686);
        check("R7 v_inc zero out_h", int'(v_inc_o), 1024);
        latch_ratio(100, 500, 100, 100);
        check("R6 h_inc zoom clamp", int'(h_inc_o), 293);
        check("R7 v_inc unity", int'(v_inc_o), 1024);
        latch_ratio(100, 0, 0, 5);
        check("R6 h_inc zero out_w", int'(h_inc_o), 1024);
        check("R7 v_inc zero height", int'(v_inc_o), 0);

        // R10 almost-full threshold
        fifo_level_i = 6'd23; #1; check("R10 level 23", int'(fifo_afull_o), 0);
        fifo_level_i = 6'd24; #1; check("R10 level 24", int'(fifo_afull_o), 1);
        fifo_level_i = 6'd63; #1; check("R10 level 63", int'(fifo_afull_o), 1);
        fifo_level_i = 6'd0;  #1; check("R10 level 0", int'(fifo_afull_o), 0);

        // R11: pixel position holds at 2047 with the horizontal strobe missing
        begin
            int n_sat;
            n_sat = 0;
            h_rise_i = 1; v_rise_i = 1; trig_cond_i = 1; fid_i = 0;
            xo_i = 11'd2047; xs_i = 11'd1; yo_i = 0; ys_i = 0;
            valid_pol_i = 1; gate_mode_i = 1; vbi_en_i = 0;
            href_i = 1; vref_i = 1;
            for (int s = 0; s < 2100; s++) begin
                step();
                if (dvalid_o) n_sat++;
                href_i = 0; vref_i = 0;
            end
            check("R11 saturated active count", n_sat, 53);
            check("R11 still active at end", int'(dvalid_o), 1);
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule